// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the host-side programming window of a four-channel DMA controller. Every host-visible port is one byte wide. Each channel has a 16-bit start address and a 16-bit transfer count, so the host reaches each of these through a single byte port. A byte-pointer state machine, shared by all channels, decides whether an access reaches the low or the high byte. A dedicated write-only port returns the pointer to its low-byte state.

Each programmed address and count lands in two copies. The base copy stays as programmed. The working copy advances by one element every time the transfer engine pulses the channel's step input. A read of a count port returns the working count, which is the residue of the transfer. A separate mode port packs a channel selector and that channel's mode bits into one written byte.

The pointer state machine has two states. `PTR_LO` is entered on reset and on a clear-port write. `PTR_HI` is entered after one access from `PTR_LO`. Each read or write of a channel port takes `PTR_LO` to `PTR_HI` and `PTR_HI` to `PTR_LO`. Any other cycle holds the state.

Top module: `dmarb_regbank`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the pointer to `PTR_LO`. It also clears every mode, every base and working count, and every base and working address.
- R2: A write to port 9 forces `PTR_LO` whatever byte is written.
- R3: Each read or write to ports 0–7 toggles the pointer once. The pointer is shared by all channels, so after a clear the first access reaches bits [7:0] and the next access reaches bits [15:8], whichever channel ports are used.
- R4: A write to port 2n places the byte, at the half chosen by the pointer, into both the base and the working address of channel n.
- R5: A write to port 2n+1 places the byte into both the base and the working count of channel n. The value is stored untranslated as the number of transfers minus one, so 0x0000 stands for one transfer and 0xFFFF for 65536 transfers.
- R6: While `rd_en` is high, `rdata` shows the half chosen by the pointer. On port 2n+1 that half comes from channel n's working count. On port 2n it comes from channel n's working address.
- R7: A write to port 8 stores bits [7:2] as the mode of the channel numbered by bits [1:0]. It leaves the pointer unchanged.
- R8: A pulse on `xfer_step[n]` decrements channel n's working count, with 0x0000 wrapping to 0xFFFF. It also increments the working address. The base copies are left unchanged.
- R9: A host write to a working register in the same cycle as that channel's step takes priority. The written byte is stored, the other byte keeps its value from before that cycle, and that register does not step.
- R10: Ports 10–15 and reads of ports 8 and 9 have no effect on the pointer or on any register, and the read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 4 | Port number |
| wdata | input | 8 | Host write byte |
| xfer_step | input | 4 | Per-channel one-element advance from the transfer engine |
| rdata | output | 8 | Read byte (combinational) |
| ptr_high | output | 1 | Byte pointer state, 1 = high byte next |
| chan_mode | output | 24 | Mode of each channel, channel n at [6n+5:6n] |
| chan_base_addr | output | 64 | Base address of each channel, channel n at [16n+15:16n] |
| chan_addr | output | 64 | Working address of each channel |
| chan_base_count | output | 64 | Base count of each channel |
| chan_count | output | 64 | Working count (residue) of each channel |

## Verification
A host write to a channel's count port and that channel's step pulse can land in the same cycle. The bench provokes this by writing one byte of channel 3's count while `xfer_step[3]` is high. It judges the result by requiring the merged value: the new low byte over the old high byte, with no decrement applied. It also requires that the pointer still toggled on that access.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
    localparam int CH_SEL_W = 2;
    localparam int BYTE_W   = 8;

    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } ptr_state_t;
endpackage

// File: rtl/dmarb_byteptr.sv
module dmarb_byteptr
    import dmarb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic access,
    output logic ptr_hi
);
    ptr_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= PTR_LO;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PTR_LO: begin
                if (clear)       state_d = PTR_LO;
                else if (access) state_d = PTR_HI;
            end
            PTR_HI: begin
                if (clear)       state_d = PTR_LO;
                else if (access) state_d = PTR_LO;
            end
            default: state_d = PTR_LO;
        endcase
    end

    always_comb begin
        ptr_hi = (state_q == PTR_HI);
    end
endmodule

// File: rtl/dmarb_chan.sv
module dmarb_chan #(
    parameter int BYTE_W = 8,
    parameter int MODE_W = 6,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hi_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              addr_we,
    input  logic              cnt_we,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_val,
    input  logic              step,
    output logic [WORD_W-1:0] base_addr,
    output logic [WORD_W-1:0] cur_addr,
    output logic [WORD_W-1:0] base_cnt,
    output logic [WORD_W-1:0] cur_cnt,
    output logic [MODE_W-1:0] mode
);
    function automatic logic [WORD_W-1:0] merge(input logic [WORD_W-1:0] old,
                                                input logic              hi,
                                                input logic [BYTE_W-1:0] b);
        logic [WORD_W-1:0] r;
        r = old;
        if (hi) r[WORD_W-1:BYTE_W] = b;
        else    r[BYTE_W-1:0]      = b;
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            cur_addr  <= '0;
            base_cnt  <= '0;
            cur_cnt   <= '0;
            mode      <= '0;
        end else begin
            if (addr_we) begin
                base_addr <= merge(base_addr, hi_sel, wdata);
                cur_addr  <= merge(cur_addr, hi_sel, wdata);
            end else if (step) begin
                cur_addr  <= cur_addr + 1'b1;
            end
            if (cnt_we) begin
                base_cnt  <= merge(base_cnt, hi_sel, wdata);
                cur_cnt   <= merge(cur_cnt, hi_sel, wdata);
            end else if (step) begin
                cur_cnt   <= cur_cnt - 1'b1;
            end
            if (mode_we) mode <= mode_val;
        end
    end
endmodule

// File: rtl/dmarb_regbank.sv
module dmarb_regbank
    import dmarb_pkg::*;
#(
    parameter int SEL_W = CH_SEL_W,
    parameter int DW    = BYTE_W,
    localparam int NCH    = 1 << SEL_W,
    localparam int WW     = 2 * DW,
    localparam int MW     = DW - SEL_W,
    localparam int PW     = SEL_W + 2,
    localparam logic [PW-1:0] MODE_PORT = PW'(2 * NCH),
    localparam logic [PW-1:0] CLR_PORT  = PW'(2 * NCH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [PW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic [NCH-1:0]    xfer_step,
    output logic [DW-1:0]     rdata,
    output logic              ptr_high,
    output logic [NCH*MW-1:0] chan_mode,
    output logic [NCH*WW-1:0] chan_base_addr,
    output logic [NCH*WW-1:0] chan_addr,
    output logic [NCH*WW-1:0] chan_base_count,
    output logic [NCH*WW-1:0] chan_count
);
    logic             is_chan;
    logic [SEL_W-1:0] ch_sel;
    logic             is_cnt;
    logic             mode_wr;
    logic [SEL_W-1:0] mode_ch;

    assign is_chan = (addr[PW-1] == 1'b0);
    assign ch_sel  = addr[SEL_W:1];
    assign is_cnt  = addr[0];
    assign mode_wr = wr_en && (addr == MODE_PORT);
    assign mode_ch = wdata[SEL_W-1:0];

    dmarb_byteptr u_ptr (
        .clk    (clk),
        .rst    (rst),
        .clear  (wr_en && (addr == CLR_PORT)),
        .access ((wr_en || rd_en) && is_chan),
        .ptr_hi (ptr_high)
    );

    logic [WW-1:0] cur_a [NCH];
    logic [WW-1:0] cur_c [NCH];

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic sel_n;
        assign sel_n = is_chan && (ch_sel == SEL_W'(n));

        dmarb_chan #(.BYTE_W(DW), .MODE_W(MW)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .hi_sel    (ptr_high),
            .wdata     (wdata),
            .addr_we   (wr_en && sel_n && !is_cnt),
            .cnt_we    (wr_en && sel_n && is_cnt),
            .mode_we   (mode_wr && (mode_ch == SEL_W'(n))),
            .mode_val  (wdata[DW-1:SEL_W]),
            .step      (xfer_step[n]),
            .base_addr (chan_base_addr[n*WW +: WW]),
            .cur_addr  (cur_a[n]),
            .base_cnt  (chan_base_count[n*WW +: WW]),
            .cur_cnt   (cur_c[n]),
            .mode      (chan_mode[n*MW +: MW])
        );
        assign chan_addr[n*WW +: WW]  = cur_a[n];
        assign chan_count[n*WW +: WW] = cur_c[n];
    end

    logic [WW-1:0] rd_word;
    always_comb begin
        rd_word = is_cnt ? cur_c[ch_sel] : cur_a[ch_sel];
        rdata   = '0;
        if (rd_en && is_chan)
            rdata = ptr_high ? rd_word[WW-1:DW] : rd_word[DW-1:0];
    end
endmodule

// File: rtl/dmarb_regbank_chk.sv
module dmarb_regbank_chk #(
    parameter int SEL_W = 2,
    parameter int DW    = 8,
    localparam int NCH  = 1 << SEL_W,
    localparam int WW   = 2 * DW,
    localparam int MW   = DW - SEL_W,
    localparam int PW   = SEL_W + 2
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [PW-1:0]     addr,
    input logic [DW-1:0]     wdata,
    input logic [NCH-1:0]    xfer_step,
    input logic [DW-1:0]     rdata,
    input logic              ptr_high,
    input logic [NCH*MW-1:0] chan_mode,
    input logic [NCH*WW-1:0] chan_addr,
    input logic [NCH*WW-1:0] chan_count
);
    localparam logic [PW-1:0] MODE_PORT = PW'(2 * NCH);
    localparam logic [PW-1:0] CLR_PORT  = PW'(2 * NCH + 1);

    logic chan_acc;
    assign chan_acc = (wr_en || rd_en) && (addr[PW-1] == 1'b0);

    a_r1_reset_ptr: assert property (@(posedge clk)
        $past(rst) |-> (!ptr_high && chan_mode == '0 && chan_count == '0));

    a_r2_clear_low: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == CLR_PORT) |=> !ptr_high);

    a_r3_toggle: assert property (@(posedge clk) disable iff (rst)
        chan_acc |=> (ptr_high != $past(ptr_high)));

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!chan_acc && !(wr_en && addr == CLR_PORT)) |=> $stable(ptr_high));

    a_r10_rdata_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[PW-1]) |-> (rdata == '0));

    a_r7_mode_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == MODE_PORT) |=>
            (chan_mode[$past(wdata[SEL_W-1:0]) * MW +: MW] == $past(wdata[DW-1:SEL_W])));

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
            (xfer_step[n] && !(wr_en && addr == PW'(2 * n + 1))) |=>
                (chan_count[n*WW +: WW] == WW'($past(chan_count[n*WW +: WW]) - 1'b1)));
        a_r8_addr_step: assert property (@(posedge clk) disable iff (rst)
            (xfer_step[n] && !(wr_en && addr == PW'(2 * n))) |=>
                (chan_addr[n*WW +: WW] == WW'($past(chan_addr[n*WW +: WW]) + 1'b1)));
    end
endmodule

bind dmarb_regbank dmarb_regbank_chk #(.SEL_W(SEL_W), .DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .xfer_step  (xfer_step),
    .rdata      (rdata),
    .ptr_high   (ptr_high),
    .chan_mode  (chan_mode),
    .chan_addr  (chan_addr),
    .chan_count (chan_count)
);

// File: tb/dmarb_regbank_test.sv
module dmarb_regbank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;
    // {is_read, port, byte}: write byte, or expected read byte
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 4'h9, 8'h00}, {1'b0, 4'h2, 8'h34}, {1'b0, 4'h2, 8'h12},
        {1'b0, 4'h3, 8'hFF}, {1'b0, 4'h3, 8'h00}, {1'b1, 4'h3, 8'hFF},
        {1'b1, 4'h3, 8'h00}, {1'b1, 4'h2, 8'h34}, {1'b1, 4'h2, 8'h12},
        {1'b0, 4'h7, 8'h01}, {1'b0, 4'h7, 8'h80}, {1'b0, 4'h9, 8'hAA},
        {1'b0, 4'h6, 8'hCD}, {1'b1, 4'h7, 8'h80}, {1'b1, 4'h7, 8'h01},
        {1'b0, 4'h9, 8'h00}, {1'b1, 4'h6, 8'hCD}, {1'b1, 4'h6, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [3:0]  xfer_step = '0;
    logic [7:0]  rdata;
    logic        ptr_high;
    logic [23:0] chan_mode;
    logic [63:0] chan_base_addr, chan_addr, chan_base_count, chan_count;
    int          n_chk = 0, n_bad = 0;
    logic [7:0]  rv;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmarb_regbank uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .xfer_step(xfer_step), .rdata(rdata), .ptr_high(ptr_high),
        .chan_mode(chan_mode), .chan_base_addr(chan_base_addr), .chan_addr(chan_addr),
        .chan_base_count(chan_base_count), .chan_count(chan_count)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic op(input bit rd, input logic [3:0] a, input logic [7:0] d,
                      input logic [3:0] stp, output logic [7:0] r);
        @(negedge clk);
        wr_en = !rd; rd_en = rd; addr = a; wdata = d; xfer_step = stp;
        #1 r = rdata;
        @(posedge clk);
        #1 wr_en = 0; rd_en = 0; xfer_step = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check("R1 reset ptr", ptr_high, 0);
        check("R1 reset counts", chan_count | chan_base_count, 0);
        check("R1 reset addrs", chan_addr | chan_base_addr | chan_mode, 0);

        for (int i = 0; i < NV; i++) begin
            op(VEC[i][12], VEC[i][11:8], VEC[i][7:0], 4'h0, rv);
            if (VEC[i][12]) check($sformatf("R6 table %0d (R3 shared ptr)", i), rv, VEC[i][7:0]);
        end
        check("R4 ch1 addr", chan_addr[31:16], 16'h1234);
        check("R5 ch1 base count", chan_base_count[31:16], 16'h00FF);
        check("R5 ch3 count", chan_count[63:48], 16'h8001);
        check("R2 ptr low after clear+2", ptr_high, 0);

        op(0, 4'h8, 8'hAA, 4'h0, rv);
        check("R7 ch2 mode", chan_mode[17:12], 6'h2A);
        check("R7 other modes", {chan_mode[23:18], chan_mode[11:0]}, 0);
        check("R7 ptr unchanged", ptr_high, 0);

        @(negedge clk); xfer_step = 4'b0010;
        repeat (3) @(posedge clk);
        #1 xfer_step = '0;
        check("R8 ch1 count", chan_count[31:16], 16'h00FC);
        check("R8 ch1 addr", chan_addr[31:16], 16'h1237);
        check("R8 ch1 base", chan_base_count[31:16], 16'h00FF);

        op(0, 4'hC, 8'h00, 4'b0001, rv);
        check("R8 ch0 wrap", chan_count[15:0], 16'hFFFF);

        op(0, 4'h7, 8'h55, 4'b1000, rv);
        check("R9 write wins over step", chan_count[63:48], 16'h8055);
        check("R9 ptr toggled", ptr_high, 1);
        op(1, 4'h7, 8'h00, 4'h0, rv);
        check("R9 readback high", rv, 8'h80);

        op(0, 4'hC, 8'h77, 4'h0, rv);
        check("R10 unused write ptr", ptr_high, 0);
        op(1, 4'hC, 8'h00, 4'h0, rv);
        check("R10 unused read", rv, 8'h00);
        op(1, 4'h0, 8'h00, 4'h0, rv);
        op(1, 4'h9, 8'h00, 4'h0, rv);
        check("R10 read clear port data", rv, 8'h00);
        check("R10 read clear port ptr", ptr_high, 1);
        check("R10 regs untouched", {chan_count[15:0], chan_mode[17:12]}, {16'hFFFF, 6'h2A});

        op(0, 4'h9, 8'h5A, 4'h0, rv);
        check("R2 clear any value", ptr_high, 0);

        @(negedge clk); rst = 1;
        @(posedge clk); #1 rst = 0;
        check("R1 mid reset ptr", ptr_high, 0);
        check("R1 mid reset state", chan_count | chan_base_count | chan_addr, 0);
        check("R1 mid reset mode", chan_mode, 0);
        finish_run();
    end
endmodule